// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path with Deselect Timing

This block is the read side of a synchronous single-port SRAM: the storage array, the read data path to the data pins, and the timing that decides when those pins are driven. A command is presented on `sel`, `we` and `addr` and captured on a rising clock edge. A captured read returns the addressed word in one of two ways, chosen by the static `pipe_mode` input. With `pipe_mode` low the word goes straight from the array register to the pins (flow-through). With `pipe_mode` high it passes through one more output register (pipelined). A four-beat burst of back-to-back reads therefore completes in 2-1-1-1 or 3-1-1-1 cycles.

A second static input, `dual_desel`, sets how long the pins stay driven after a read stream ends with a non-read command (a deselect or a write). With single-cycle deselect the drivers turn off in the first cycle after the last read word. With dual-cycle deselect the last word is held on the pins for one more cycle, so the turn-off lines up with the read latency. In both modes, a deselect captured right after a read still lets that read's word reach the pins. The output-enable input `oe` and the sleep input `sleep` act on the drivers without waiting for a clock edge. While `sleep` is high, no command is captured and the array keeps its contents. The tri-state pins are modelled as a data word `dq_out` plus a drive flag `dq_en`. When it is not floating the pins, a board-level integration usually ties `pipe_mode` high and `dual_desel` low.

Top module: `srd_top`

## Requirements
- R1: A synchronous reset clears every read in flight, so `dq_en` is low in the cycle after the reset edge even when a read was captured just before it.
- R2: With `pipe_mode` = 0, a read captured at edge k drives `dq_en` = 1 and the addressed word on `dq_out` in the cycle that follows edge k.
- R3: With `pipe_mode` = 1, a read captured at edge k drives the word in the cycle after edge k+1, and `dq_en` is still low in the cycle after edge k when the previous command was not a read.
- R4: Reads captured on consecutive edges appear on consecutive cycles, one word per cycle in address-issue order, in both output modes.
- R5: With `dual_desel` = 0, when a non-read command is captured at the edge after the last read, `dq_en` is low in the cycle right after the last read word.
- R6: With `dual_desel` = 1, the last read word stays on `dq_out` with `dq_en` high for one extra cycle, and `dq_en` is low in the cycle after that.
- R7: A write (`sel` = 1, `we` = 1) stores `wdata` at `addr`, and a read of that address on the next edge returns the new word. A captured write never drives the pins.
- R8: `oe` = 0 forces `dq_en` low at once, without a clock edge. Raising `oe` again restores driving within the same cycle.
- R9: `sleep` = 1 forces `dq_en` low at once. Reads and writes presented while `sleep` is high are ignored, and the stored words are unchanged after `sleep` returns low.
- R10: Whenever `dq_en` is low, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | Static: 1 = registered output, 0 = flow-through |
| dual_desel | input | 1 | Static: 1 = dual-cycle deselect, 0 = single-cycle deselect |
| sel | input | 1 | Command select; 0 = deselect |
| we | input | 1 | With sel = 1: 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_out | output | DW | Data bus value (zero when not driven) |
| dq_en | output | 1 | Bus drive flag; 0 models high impedance |

## Verification
The bench builds the block with AW = 4 and DW = 16. This gives a 16-word array that is filled entirely with distinct patterns, so every word returned on the pins identifies its address. It switches between all four combinations of `pipe_mode` and `dual_desel`, while idle, within one run. That puts single reads, bursts, the extra hold cycle and the early turn-off side by side. Mid-cycle pulses of `oe` and `sleep`, commands issued during sleep, and a reset landing on a read in flight probe the asynchronous and boundary behaviour.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_READ  = 2'd1,
    CAP_WRITE = 2'd2
  } cap_e;

  // Command seen at a capture edge; sleep blocks every capture.
  function automatic cap_e cap_decode(input logic sel, input logic we, input logic sleep);
    if (sleep || !sel) return CAP_IDLE;
    if (we) return CAP_WRITE;
    return CAP_READ;
  endfunction

endpackage

// File: rtl/srd_array.sv
module srd_array
  import srd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          we,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_flag,
  output logic [DW-1:0] rd_word
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  cap_e          cap;

  assign cap = cap_decode(sel, we, sleep);

  // Single port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (cap == CAP_WRITE) mem[addr] <= wdata;
    if (cap == CAP_READ)  rd_word   <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_flag <= 1'b0;
    else     rd_flag <= (cap == CAP_READ);
  end

  // R9
  sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rd_flag);

  // R7
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && we) |=> !rd_flag);

endmodule

// File: rtl/srd_outstage.sv
module srd_outstage #(
  parameter int DW     = 32,
  parameter int EXTRA  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_flag,
  input  logic [DW-1:0]   rd_word,
  output logic [EXTRA:0]  flags,
  output logic [DW-1:0]   pipe_word
);

  logic [EXTRA-1:0] hist_q;

  // Read-valid history: bit i is the read flag delayed by i+1 edges.
  generate
    if (EXTRA == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= rd_flag;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[EXTRA-2:0], rd_flag};
      end
    end
  endgenerate

  assign flags = {hist_q, rd_flag};

  // Output register loads only on a fresh read word, so it holds the
  // last word through a dual-cycle deselect tail.
  always_ff @(posedge clk) begin
    if (rd_flag) pipe_word <= rd_word;
  end

endmodule

// File: rtl/srd_desel.sv
module srd_desel #(
  parameter int NF = 3
) (
  input  logic          pipe_mode,
  input  logic          dual_desel,
  input  logic [NF-1:0] flags,
  output logic          drv
);

  logic valid_now;
  logic valid_prev;

  always_comb begin
    if (pipe_mode) begin
      valid_now  = flags[1];
      valid_prev = flags[2];
    end else begin
      valid_now  = flags[0];
      valid_prev = flags[1];
    end
    drv = valid_now | (dual_desel & valid_prev);
  end

endmodule

// File: rtl/srd_top.sv
module srd_top #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic          dual_desel,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe,
  input  logic          sleep,
  output logic [DW-1:0] dq_out,
  output logic          dq_en
);

  localparam int EXTRA = 2;
  localparam int NF    = EXTRA + 1;

  logic          rd_flag;
  logic [DW-1:0] rd_word;
  logic [NF-1:0] flags;
  logic [DW-1:0] pipe_word;
  logic          drv;
  logic [DW-1:0] sel_word;

  srd_array #(.AW(AW), .DW(DW)) array_i (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .sleep(sleep),
    .addr(addr), .wdata(wdata), .rd_flag(rd_flag), .rd_word(rd_word)
  );

  srd_outstage #(.DW(DW), .EXTRA(EXTRA)) out_i (
    .clk(clk), .rst(rst), .rd_flag(rd_flag), .rd_word(rd_word),
    .flags(flags), .pipe_word(pipe_word)
  );

  srd_desel #(.NF(NF)) desel_i (
    .pipe_mode(pipe_mode), .dual_desel(dual_desel), .flags(flags), .drv(drv)
  );

  assign sel_word = pipe_mode ? pipe_word : rd_word;
  assign dq_en    = oe & drv & ~sleep;
  assign dq_out   = dq_en ? sel_word : '0;

  // R2
  ft_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && rd_flag) |-> drv);

  // R3
  pipe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && rd_flag) |=> (drv || !pipe_mode));

endmodule

// File: tb/srd_tb.sv
module srd_top_tb_top;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pipe_mode = 1'b1;
  logic          dual_desel = 1'b0;
  logic          sel = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_en;

  srd_top #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .dual_desel(dual_desel),
    .sel(sel), .we(we), .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
    .dq_out(dq_out), .dq_en(dq_en)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    int            cyc;
    logic          en;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] model [DEPTH];
  int            last_rd;
  logic [AW-1:0] last_a;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
    end
  endtask

  function automatic void push(input int c, input logic e, input logic [DW-1:0] d, input string r);
    exp_t it;
    int   i;
    it.cyc = c; it.en = e; it.data = d; it.req = r;
    i = 0;
    while (i < sb.size() && sb[i].cyc <= c) i++;
    sb.insert(i, it);
  endfunction

  function automatic int lat();
    return pipe_mode ? 2 : 1;
  endfunction

  // Monitor: compares the pins against queued expectations.
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        exp_t it;
        it = sb.pop_front();
        if (it.cyc < cyc) begin
          check(1'b0, it.req, it.cyc, cyc);
        end else if (it.en) begin
          check(dq_en == 1'b1, it.req, int'(dq_en), 1);
          check(dq_out == it.data, it.req, int'(dq_out), int'(it.data));
        end else begin
          check(dq_en == 1'b0, it.req, int'(dq_en), 0);
          check(dq_out == '0, "R10", int'(dq_out), 0);
        end
      end
    end
  end

  task automatic cmd(input logic s, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel = s; we = w; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string r);
    push(cyc + lat(), 1'b1, model[a], r);
    last_rd = cyc;
    last_a = a;
    cmd(1'b1, 1'b0, a, '0);
  endtask

  // Expected turn-off after the last read, given the deselect mode.
  task automatic tail(input string r);
    if (dual_desel) begin
      push(last_rd + lat() + 1, 1'b1, model[last_a], r);
      push(last_rd + lat() + 2, 1'b0, '0, r);
    end else begin
      push(last_rd + lat() + 1, 1'b0, '0, r);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: nothing driven straight out of reset
    check(dq_en == 1'b0, "R1", int'(dq_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(dq_en == 1'b0, "R1", int'(dq_en), 0);

    // Fill the array (R7 writes)
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 16'hA500 ^ (16'(a) * 16'h0111);
      cmd(1'b1, 1'b1, AW'(a), model[a]);
    end
    idle(2);

    // Pipelined, single-cycle deselect: single read (R3, R5)
    push(cyc + 1, 1'b0, '0, "R3");
    rd(4'd3, "R3");
    tail("R5");
    idle(4);

    // Pipelined burst 3-1-1-1 (R4)
    for (int a = 4; a < 8; a++) rd(AW'(a), "R4");
    tail("R5");
    idle(4);

    // Write then immediate read of same address (R7)
    model[9] = 16'h5A3C;
    cmd(1'b1, 1'b1, 4'd9, 16'h5A3C);
    rd(4'd9, "R7");
    tail("R7");
    idle(4);

    // Flow-through, single-cycle deselect (R2, R5)
    pipe_mode = 1'b0;
    rd(4'd10, "R2");
    tail("R5");
    idle(3);
    for (int a = 12; a < 16; a++) rd(AW'(a), "R4");
    tail("R5");
    idle(4);

    // Flow-through, dual-cycle deselect (R6)
    dual_desel = 1'b1;
    rd(4'd1, "R6");
    tail("R6");
    idle(4);
    for (int a = 0; a < 3; a++) rd(AW'(a), "R6");
    tail("R6");
    idle(4);

    // Pipelined, dual-cycle deselect (R6)
    pipe_mode = 1'b1;
    rd(4'd11, "R6");
    tail("R6");
    idle(5);
    rd(4'd8, "R6");
    rd(4'd2, "R6");
    tail("R6");
    idle(5);

    // Asynchronous output enable (R8)
    dual_desel = 1'b0;
    rd(4'd1, "R8");
    rd(4'd2, "R8");
    rd(4'd3, "R8");
    tail("R8");
    sel = 1'b0;
    #3 oe = 1'b0;
    #1 check(dq_en == 1'b0, "R8", int'(dq_en), 0);
    check(dq_out == '0, "R10", int'(dq_out), 0);
    oe = 1'b1;
    #1 check(dq_en == 1'b1, "R8", int'(dq_en), 1);
    @(negedge clk);
    idle(4);

    // Asynchronous sleep pulse while driving (R9)
    rd(4'd5, "R9");
    rd(4'd6, "R9");
    tail("R9");
    sel = 1'b0;
    #4 sleep = 1'b1;
    #1 check(dq_en == 1'b0, "R9", int'(dq_en), 0);
    sleep = 1'b0;
    #1 check(dq_en == 1'b1, "R9", int'(dq_en), 1);
    @(negedge clk);
    idle(4);

    // Commands during sleep are ignored; contents retained (R9)
    sleep = 1'b1;
    cmd(1'b1, 1'b1, 4'd2, 16'hDEAD);
    push(cyc + 1, 1'b0, '0, "R9");
    push(cyc + 2, 1'b0, '0, "R9");
    cmd(1'b1, 1'b0, 4'd5, '0);
    idle(3);
    sleep = 1'b0;
    idle(2);
    rd(4'd2, "R9");
    tail("R9");
    idle(4);

    // Reset landing on a read in flight (R1)
    cmd(1'b1, 1'b0, 4'd7, '0);
    rst = 1'b1;
    sel = 1'b0;
    @(negedge clk);
    check(dq_en == 1'b0, "R1", int'(dq_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(dq_en == 1'b0, "R1", int'(dq_en), 0);
    idle(3);

    check(sb.size() == 0, "scoreboard drain", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule